// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a watchdog timer behind a small register interface. Software writes a control word once after reset. That word picks a clock prescaler, a count period, a refresh window, what happens in low-power mode and the action taken on expiry. The counter stays idle until software performs its first refresh. From then on it counts down in prescaled ticks, and software must keep refreshing it from inside the configured window. If the count runs out, or if a refresh lands outside the window, the block either sends a one-cycle reset pulse to the system reset controller or raises an interrupt request. The remaining count can be read at any time.

A refresh is a two-write key sequence to the refresh register: 0x0123 and then 0x3210. Status flags record underflow and refresh errors. Both flags are sticky and are cleared by writing 1 to them.

A controller with four states drives the counter:
- `ST_UNCFG` is the state after reset.
- `ST_UNCFG` goes to `ST_ARMED` once the control word is written.
- `ST_ARMED` goes to `ST_COUNT` on the first refresh.
- `ST_COUNT` stays in `ST_COUNT` on an in-window refresh, which reloads the count.
- `ST_COUNT` goes to `ST_EXPIRED` on underflow or on an out-of-window refresh.
- `ST_EXPIRED` goes back to `ST_COUNT` on any refresh.

Top module: `wdog_window_top`

## Requirements
- R1: The control register at address 0 takes only the first write after reset. Later writes change neither its readback nor its behaviour until the next reset. Field layout:
  - bits [3:0]: divisor log2
  - bits [5:4]: period select
  - bits [8:6]: window
  - bit 9: run during low power
  - bit 10: expiry action, 1 = interrupt
- R2: The prescaler divides by 2 to the power of the divisor field. Legal field values are 2, 6, 7, 8, 9, 10, 11 and 13. Any other value divides by 4. The count drops by one each time the divisor's number of clock cycles passes.
- R3: Period select 0, 1, 2 and 3 gives a start count of 256, 4096, 16384 and 65536.
- R4: Before the first refresh the count (address 3) reads 0, and no reset or interrupt is raised however long the block waits.
- R5: A refresh is the write of 0x0123 followed by the write of 0x3210 to address 1. Any other value written to address 1 between them cancels the sequence.
- R6: A refresh loads the full period. When the count reaches 0 the block expires, exactly period × divisor cycles after the load.
- R7: Window codes and the counts at which a refresh is accepted (P is the period, q = P/4):
  - 1: count above 3q
  - 2: count above 2q and at most 3q
  - 3: count above q and at most 2q
  - 4: count at most q
  - 0, 5, 6, 7: any count

  A refresh outside the window expires the block and sets status bit 1.
- R8: While lp_req is high and control bit 9 is 0, the count and prescaler hold. With bit 9 set, counting continues.
- R9: With action 0, expiry produces a single-cycle high pulse on wdt_rst_o and no interrupt. With action 1, expiry raises wdt_irq_o, which stays high while any status flag is set, and never pulses wdt_rst_o.
- R10: Status (address 2) bit 0 is underflow and bit 1 is refresh error. Both are sticky and are cleared by writing 1 to the bit.
- R11: After expiry the count holds 0. The next refresh reloads the count without a window check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 refresh, 2 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address (0 control, 2 status, 3 count) |
| rd_data | output | 32 | Combinational read data |
| lp_req | input | 1 | Low-power request |
| wdt_rst_o | output | 1 | Single-cycle reset request |
| wdt_irq_o | output | 1 | Interrupt request level |

## Verification
A write affects the registers at the clock edge where it is applied, and rd_data shows the new value right after that edge. So the count reads the full period straight after the second key write. After a load, the count drops at the edge that ends each divisor-long run of cycles. This makes the count equal period − floor(k / divisor) after k edges. Expiry is registered at edge period × divisor: wdt_rst_o is high for the one cycle after that edge, and the status flag and the zero count appear at the same time. The bench drives inputs and samples outputs on the falling edge and counts rising edges from the load, so each check falls exactly on, or one cycle before, the edge where the value changes.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    localparam logic [1:0] ADR_CTRL  = 2'd0;
    localparam logic [1:0] ADR_KICK  = 2'd1;
    localparam logic [1:0] ADR_STAT  = 2'd2;
    localparam logic [1:0] ADR_COUNT = 2'd3;

    localparam int unsigned KEY_ARM  = 32'h0000_0123;
    localparam int unsigned KEY_FIRE = 32'h0000_3210;

    typedef enum logic [1:0] {
        ST_UNCFG,
        ST_ARMED,
        ST_COUNT,
        ST_EXPIRED
    } wdw_state_e;

    // control word, bit 10 down to bit 0
    typedef struct packed {
        logic       act_irq;
        logic       lp_run;
        logic [2:0] win;
        logic [1:0] per_sel;
        logic [3:0] div_log2;
    } wdw_ctrl_t;

    localparam int CTRL_W = $bits(wdw_ctrl_t);

    function automatic logic [3:0] legal_div_log2(input logic [3:0] code);
        case (code)
            4'd2, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11, 4'd13: return code;
            default: return 4'd2;
        endcase
    endfunction

    function automatic int unsigned period_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 32'd256;
            2'd1:    return 32'd4096;
            2'd2:    return 32'd16384;
            default: return 32'd65536;
        endcase
    endfunction

    function automatic logic in_window(input logic [2:0] w, input int unsigned c,
                                       input int unsigned p);
        int unsigned q;
        q = p >> 2;
        case (w)
            3'd1:    return c > 3 * q;
            3'd2:    return (c > 2 * q) && (c <= 3 * q);
            3'd3:    return (c > q) && (c <= 2 * q);
            3'd4:    return c <= q;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/wdw_regs.sv
module wdw_regs
    import wdw_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_uf,
    input  logic              set_err,
    output wdw_ctrl_t         ctrl_q,
    output logic              cfg_done,
    output logic              refresh_stb,
    output logic              uf_flag,
    output logic              err_flag
);

    logic key_half_q;
    logic wr_ctrl, wr_kick, wr_stat;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    assign wr_kick = wr_en && (wr_addr == ADDR_W'(ADR_KICK));
    assign wr_stat = wr_en && (wr_addr == ADDR_W'(ADR_STAT));

    assign refresh_stb = wr_kick && key_half_q && (wr_data == DATA_W'(KEY_FIRE));

    // write-once control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cfg_done <= 1'b0;
        end else if (wr_ctrl && !cfg_done) begin
            ctrl_q   <= wdw_ctrl_t'(wr_data[CTRL_W-1:0]);
            cfg_done <= 1'b1;
        end
    end

    // two-step refresh key
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_half_q <= 1'b0;
        end else if (wr_kick) begin
            key_half_q <= (wr_data == DATA_W'(KEY_ARM));
        end
    end

    // sticky status, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uf_flag  <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (set_uf)                      uf_flag  <= 1'b1;
            else if (wr_stat && wr_data[0])  uf_flag  <= 1'b0;
            if (set_err)                     err_flag <= 1'b1;
            else if (wr_stat && wr_data[1])  err_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wdw_prescaler.sv
module wdw_prescaler
    import wdw_pkg::*;
#(
    parameter int PRE_W = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clr,
    input  logic [3:0] div_log2,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;
    logic [3:0]       eff_log2;

    assign eff_log2 = legal_div_log2(div_log2);
    assign last     = PRE_W'((32'd1 << eff_log2) - 32'd1);
    assign tick     = en && (pre_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (clr)    pre_q <= '0;
        else if (tick)   pre_q <= '0;
        else if (en)     pre_q <= pre_q + PRE_W'(1);
    end

endmodule

// File: rtl/wdw_core.sv
module wdw_core
    import wdw_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdw_ctrl_t        ctrl_q,
    input  logic             cfg_done,
    input  logic             refresh_stb,
    input  logic             lp_req,
    input  logic             tick,
    output logic             run_en,
    output logic             load,
    output logic [CNT_W-1:0] cnt_q,
    output wdw_state_e       st_q,
    output logic             set_uf,
    output logic             set_err,
    output logic             rst_pulse
);

    wdw_state_e       st_d;
    logic [CNT_W-1:0] period;
    logic             win_ok;
    logic             hold;

    assign period = CNT_W'(period_of(ctrl_q.per_sel));
    assign win_ok = in_window(ctrl_q.win, 32'(cnt_q), 32'(period));
    assign hold   = lp_req && !ctrl_q.lp_run;
    assign run_en = (st_q == ST_COUNT) && !hold;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_UNCFG;
        else        st_q <= st_d;
    end

    // transitions and events
    always_comb begin
        st_d    = st_q;
        load    = 1'b0;
        set_uf  = 1'b0;
        set_err = 1'b0;
        unique case (st_q)
            ST_UNCFG: begin
                if (cfg_done) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (refresh_stb) begin
                    load = 1'b1;
                    st_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (refresh_stb) begin
                    if (win_ok) begin
                        load = 1'b1;
                    end else begin
                        set_err = 1'b1;
                        st_d    = ST_EXPIRED;
                    end
                end else if (tick && (cnt_q == CNT_W'(1))) begin
                    set_uf = 1'b1;
                    st_d   = ST_EXPIRED;
                end
            end
            ST_EXPIRED: begin
                if (refresh_stb) begin
                    load = 1'b1;
                    st_d = ST_COUNT;
                end
            end
            default: st_d = ST_UNCFG;
        endcase
    end

    // outputs: counter and reset pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= (set_uf || set_err) && !ctrl_q.act_irq;
            if (load)                    cnt_q <= period;
            else if (set_uf || set_err)  cnt_q <= '0;
            else if (tick)               cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
    import wdw_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 17,
    parameter int PRE_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              lp_req,
    output logic              wdt_rst_o,
    output logic              wdt_irq_o
);

    wdw_ctrl_t        ctrl_q;
    logic             cfg_done, refresh_stb, uf_flag, err_flag;
    logic             set_uf, set_err, tick, run_en, load, rst_pulse;
    logic [CNT_W-1:0] cnt_q;
    wdw_state_e       st_q;

    wdw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .set_uf(set_uf), .set_err(set_err), .ctrl_q(ctrl_q), .cfg_done(cfg_done),
        .refresh_stb(refresh_stb), .uf_flag(uf_flag), .err_flag(err_flag)
    );

    wdw_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(run_en), .clr(load),
        .div_log2(ctrl_q.div_log2), .tick(tick)
    );

    wdw_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .cfg_done(cfg_done),
        .refresh_stb(refresh_stb), .lp_req(lp_req), .tick(tick), .run_en(run_en),
        .load(load), .cnt_q(cnt_q), .st_q(st_q), .set_uf(set_uf), .set_err(set_err),
        .rst_pulse(rst_pulse)
    );

    assign wdt_rst_o = rst_pulse;
    assign wdt_irq_o = ctrl_q.act_irq && (uf_flag || err_flag);

    always_comb begin
        case (rd_addr)
            ADDR_W'(ADR_CTRL):  rd_data = DATA_W'(ctrl_q);
            ADDR_W'(ADR_STAT):  rd_data = DATA_W'({err_flag, uf_flag});
            ADDR_W'(ADR_COUNT): rd_data = DATA_W'(cnt_q);
            default:            rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wdw_checker.sv
module wdw_checker
    import wdw_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_uf,
    input logic             lp_req,
    input wdw_ctrl_t        ctrl_q,
    input logic             cfg_done,
    input wdw_state_e       st_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             refresh_stb,
    input logic             uf_flag,
    input logic             rst_o,
    input logic             irq_o
);

    assert_ctrl_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> $stable(ctrl_q));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UNCFG || st_q == ST_ARMED) |-> (cnt_q == '0));

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(period_of(ctrl_q.per_sel)));

    assert_lp_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && lp_req && !ctrl_q.lp_run && !refresh_stb) |=> $stable(cnt_q));

    assert_rst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> !rst_o);

    assert_rst_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |-> !ctrl_q.act_irq);

    assert_irq_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl_q.act_irq);

    assert_uf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !clr_uf) |=> uf_flag);

    assert_expired_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXPIRED) |-> (cnt_q == '0));

endmodule

bind wdog_window_top wdw_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .clr_uf(wr_en && (wr_addr == ADDR_W'(wdw_pkg::ADR_STAT)) && wr_data[0]),
    .lp_req(lp_req), .ctrl_q(ctrl_q), .cfg_done(cfg_done), .st_q(st_q), .cnt_q(cnt_q),
    .refresh_stb(refresh_stb), .uf_flag(uf_flag), .rst_o(wdt_rst_o), .irq_o(wdt_irq_o)
);

// File: tb/tb_wdog_window_top.sv
module tb_wdog_window_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        lp_req = 1'b0;
    logic        wdt_rst_o, wdt_irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wdog_window_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lp_req(lp_req),
        .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; lp_req = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic kick();
        wr(2'd1, 32'h0123);
        wr(2'd1, 32'h3210);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(2'd0, v); chk("R1 ctrl after reset", v, 0);
        rd(2'd2, v); chk("R10 status after reset", v, 0);
        rd(2'd3, v); chk("R4 count after reset", v, 0);
        chk("R9 outputs idle", {30'd0, wdt_rst_o, wdt_irq_o}, 0);
    endtask

    task automatic t_idle_until_refresh();
        logic [31:0] v;
        int pulses = 0;
        do_reset();
        wr(2'd0, 32'h002);
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (wdt_rst_o) pulses++;
        end
        rd(2'd3, v); chk("R4 count idle", v, 0);
        chk("R4 no reset while idle", pulses, 0);
        rd(2'd2, v); chk("R4 status idle", v, 0);
    endtask

    task automatic t_write_once();
        logic [31:0] v;
        do_reset();
        wr(2'd0, 32'h002);
        wr(2'd0, 32'h03A);
        rd(2'd0, v); chk("R1 second write ignored", v, 32'h002);
        kick();
        rd(2'd3, v); chk("R1 period from first write", v, 256);
    endtask

    task automatic t_key_sequence();
        logic [31:0] v;
        do_reset();
        wr(2'd0, 32'h002);
        wr(2'd1, 32'h0123);
        wr(2'd1, 32'h5555);
        wr(2'd1, 32'h3210);
        rd(2'd3, v); chk("R5 broken key ignored", v, 0);
        wr(2'd1, 32'h3210);
        rd(2'd3, v); chk("R5 lone second key ignored", v, 0);
        kick();
        rd(2'd3, v); chk("R5 full key starts", v, 256);
    endtask

    task automatic t_periods();
        logic [31:0] v;
        do_reset(); wr(2'd0, 32'h012); kick();
        rd(2'd3, v); chk("R3 period 4096", v, 4096);
        do_reset(); wr(2'd0, 32'h022); kick();
        rd(2'd3, v); chk("R3 period 16384", v, 16384);
        do_reset(); wr(2'd0, 32'h032); kick();
        rd(2'd3, v); chk("R3 period 65536", v, 65536);
    endtask

    task automatic t_divisors();
        logic [31:0] v;
        do_reset(); wr(2'd0, 32'h006); kick();
        wait_cyc(63);
        rd(2'd3, v); chk("R2 div64 before tick", v, 256);
        wait_cyc(1);
        rd(2'd3, v); chk("R2 div64 at tick", v, 255);
        do_reset(); wr(2'd0, 32'h003); kick();
        wait_cyc(3);
        rd(2'd3, v); chk("R2 illegal code before tick", v, 256);
        wait_cyc(1);
        rd(2'd3, v); chk("R2 illegal code divides by 4", v, 255);
    endtask

    task automatic t_expiry_reset();
        logic [31:0] v;
        do_reset(); wr(2'd0, 32'h002); kick();
        wait_cyc(500);
        kick();
        rd(2'd3, v); chk("R6 reload to period", v, 256);
        wait_cyc(1023);
        rd(2'd3, v); chk("R6 count one before expiry", v, 1);
        chk("R9 no pulse before expiry", wdt_rst_o, 0);
        wait_cyc(1);
        chk("R9 reset pulse on expiry", wdt_rst_o, 1);
        chk("R9 no irq in reset mode", wdt_irq_o, 0);
        rd(2'd2, v); chk("R10 underflow flag", v, 1);
        wait_cyc(1);
        chk("R9 pulse one cycle", wdt_rst_o, 0);
        wait_cyc(30);
        rd(2'd3, v); chk("R11 count holds zero", v, 0);
        rd(2'd2, v); chk("R10 flag sticky", v, 1);
        wr(2'd2, 32'h1);
        rd(2'd2, v); chk("R10 write one clears", v, 0);
    endtask

    task automatic t_window_first_quarter();
        logic [31:0] v;
        do_reset(); wr(2'd0, 32'h042); kick();
        wait_cyc(100);
        kick();
        rd(2'd3, v); chk("R7 in-window refresh reloads", v, 256);
        rd(2'd2, v); chk("R7 no error in window", v, 0);
        wait_cyc(300);
        kick();
        chk("R7 late refresh resets", wdt_rst_o, 1);
        rd(2'd2, v); chk("R7 error flag", v, 2);
        rd(2'd3, v); chk("R7 count cleared", v, 0);
    endtask

    task automatic t_window_last_quarter_irq();
        logic [31:0] v;
        do_reset(); wr(2'd0, 32'h502); kick();
        wait_cyc(10);
        kick();
        chk("R9 irq on early refresh", wdt_irq_o, 1);
        chk("R9 no reset pulse in irq mode", wdt_rst_o, 0);
        rd(2'd2, v); chk("R7 early refresh error", v, 2);
        wait_cyc(40);
        rd(2'd3, v); chk("R11 count zero after error", v, 0);
        wr(2'd2, 32'h2);
        rd(2'd2, v); chk("R10 error cleared", v, 0);
        chk("R10 irq drops when cleared", wdt_irq_o, 0);
        kick();
        rd(2'd3, v); chk("R11 restart without window check", v, 256);
        rd(2'd2, v); chk("R11 no error on restart", v, 0);
        wait_cyc(800);
        kick();
        rd(2'd3, v); chk("R7 last-quarter refresh ok", v, 256);
        rd(2'd2, v); chk("R7 no error last quarter", v, 0);
    endtask

    task automatic t_irq_underflow();
        logic [31:0] v;
        int pulses = 0;
        do_reset(); wr(2'd0, 32'h402); kick();
        for (int i = 0; i < 1030; i++) begin
            @(negedge clk);
            if (wdt_rst_o) pulses++;
        end
        chk("R9 irq mode never pulses reset", pulses, 0);
        chk("R9 irq on underflow", wdt_irq_o, 1);
        rd(2'd2, v); chk("R10 underflow flag irq mode", v, 1);
        wait_cyc(20);
        chk("R9 irq level holds", wdt_irq_o, 1);
    endtask

    task automatic t_low_power();
        logic [31:0] v;
        do_reset(); wr(2'd0, 32'h002); kick();
        wait_cyc(40);
        rd(2'd3, v); chk("R8 count before hold", v, 246);
        lp_req = 1'b1;
        wait_cyc(100);
        rd(2'd3, v); chk("R8 count frozen", v, 246);
        lp_req = 1'b0;
        wait_cyc(4);
        rd(2'd3, v); chk("R8 count resumes", v, 245);
        do_reset(); wr(2'd0, 32'h202); kick();
        lp_req = 1'b1;
        wait_cyc(40);
        rd(2'd3, v); chk("R8 keeps running when enabled", v, 246);
        lp_req = 1'b0;
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_idle_until_refresh();
                t_write_once();
                t_key_sequence();
                t_periods();
                t_divisors();
                t_expiry_reset();
                t_window_first_quarter();
                t_window_last_quarter_irq();
                t_irq_underflow();
                t_low_power();
            end
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule